// File: doc/BRIEF.md
# Sleep and Wake Power Controller

This block sequences a network controller into and out of its hardware power-saving states. An active-low sleep request pin is passed through a synchroniser. Two conditions hold the request back: a short guard window after hardware reset, and any bus activity. Once the request is accepted, the block sends one internal soft-reset pulse. It then enters one of two sleep depths. A sticky "stay awake" configuration bit and the selected network port decide which depth.

In the deep state every power domain is switched off, and nothing except the sleep pin has any effect. In the light state only the link receive monitor stays powered, so the link-status LED can still report a good link. That LED can drive external logic that releases the sleep pin. When the sleep pin is released the block returns to normal operation and sets a wake status flag. This flag raises the interrupt request through its own enable, independent of the master interrupt enable, because the entry soft reset clears the master enable.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: The sleep pin passes through two synchroniser flops. If `sleep_n` is first sampled low at clock edge k, the guard window has expired and the bus is idle, then `soft_rst` is high for the cycle that follows edge k+2.
- R2: Sleep entry produces a `soft_rst` pulse exactly one cycle long, followed by a sleep state. The pulse clears the master interrupt enable. The sleep-interrupt enable and the sleep-interrupt status survive the pulse.
- R3: The deep state is chosen when `cfg_awake`=0 at entry. In the deep state `core_en`, `rxmon_en`, `led_en`, `tx_beat_en`, `link_led` and `irq` are all 0. Control writes, changes to `cfg_awake` and all other inputs except `sleep_n` have no effect until the block wakes.
- R4: The light state is chosen when `cfg_awake`=1 and `port_is_tp`=1 at entry. In the light state `rxmon_en`=1, while `core_en`, `led_en` and `tx_beat_en` are 0, so no link beat pulses are sent.
- R5: Outside the deep state, `link_led` = `cfg_lnk_led_en` AND `link_good`.
- R6: When `cfg_awake`=1 but `port_is_tp`=0 at entry, the block enters the deep state.
- R7: While `bus_busy`=1, a synchronised sleep request does not start entry. Entry begins on the first clock edge at which `bus_busy` is 0.
- R8: No entry starts at the first three clock edges after `rst_n` is released, even if `sleep_n` is held low throughout.
- R9: If `sleep_n` is first sampled high at edge j while asleep, the block is back in normal operation (`core_en`=1) after edge j+2 and the sleep-interrupt status is set. `irq` then follows the sleep-interrupt enable, whatever the value of the master enable.
- R10: A control write with `ctl_slp_clr`=1 in normal operation clears the sleep-interrupt status at that clock edge (write 1 to clear).
- R11: In normal operation, `irq` = (master enable AND `core_irq_src`) OR (sleep-interrupt enable AND sleep-interrupt status). A control write (`ctl_wr`=1) loads the master enable from `ctl_master_ie` and the sleep-interrupt enable from `ctl_slp_ie`.
- R12: After `rst_n` the block is in normal operation. All enables (`core_en`, `rxmon_en`, `led_en`, `tx_beat_en`) are 1, `soft_rst` is 0, and `irq` is 0 because both interrupt enables and the status are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| sleep_n | input | 1 | Asynchronous active-low sleep request |
| cfg_awake | input | 1 | 1 selects the light sleep depth |
| cfg_lnk_led_en | input | 1 | Enables the good-link indication on the LED |
| port_is_tp | input | 1 | Twisted-pair port is the selected network port |
| bus_busy | input | 1 | Bus request or bus cycle in progress |
| link_good | input | 1 | Link beat pulses or valid frames seen by the receive monitor |
| core_irq_src | input | 1 | Combined ordinary interrupt sources of the core |
| ctl_wr | input | 1 | Control write strobe |
| ctl_master_ie | input | 1 | Write data for the master interrupt enable |
| ctl_slp_ie | input | 1 | Write data for the sleep-interrupt enable |
| ctl_slp_clr | input | 1 | Write 1 to clear the sleep-interrupt status |
| core_en | output | 1 | Core domain enable |
| rxmon_en | output | 1 | Link receive monitor domain enable |
| led_en | output | 1 | Enable for the LEDs other than link status |
| tx_beat_en | output | 1 | Link beat transmit enable |
| soft_rst | output | 1 | One-cycle internal soft-reset pulse |
| link_led | output | 1 | Link-status LED output |
| irq | output | 1 | Interrupt request |

## Verification
The hardest condition to reach from the ports is entry directly out of hardware reset with the sleep pin already low. The synchroniser would otherwise let entry happen one edge earlier, so the guard window is the only thing holding it back. The bench holds `sleep_n` low through reset and samples `soft_rst` on each edge after release. A second hard case is proving that the master enable was cleared by the entry pulse rather than by a write. The bench sets the master enable before sleeping, keeps `core_irq_src` low while asleep, and raises it only after waking, with the sleep-interrupt enable off.

// File: rtl/pwr_pkg.sv
// Package: shared state type for the sleep and wake controller.
// Assumes: one clock domain after the sleep pin synchroniser.
package pwr_pkg;
    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_ENTRY = 2'd1,
        PS_DEEP  = 2'd2,
        PS_LIGHT = 2'd3
    } pwr_state_t;
endpackage

// File: rtl/pwr_sync.sv
// Module: multi-flop synchroniser for an active-low asynchronous pin.
// Assumes: the pin is level-held for several cycles; reset value is "inactive" (1).
module pwr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_n,
    output logic dout_n
);
    logic [STAGES-1:0] chain;

    // Shift the pin through STAGES flops, resetting to the inactive level.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din_n};
    end

    assign dout_n = chain[STAGES-1];
endmodule

// File: rtl/pwr_fsm.sv
// Module: sleep sequencing state machine with a post-reset guard window.
// Assumes: sleep_req is already synchronous; cfg inputs are sampled only at entry.
module pwr_fsm
    import pwr_pkg::*;
#(
    parameter int GUARD_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       cfg_awake,
    input  logic       port_is_tp,
    input  logic       bus_busy,
    output pwr_state_t state,
    output logic       wake_evt
);
    localparam int GW = $clog2(GUARD_CYC + 1);

    logic [GW-1:0] guard_cnt;
    logic          guard_done;

    assign guard_done = (guard_cnt == GW'(GUARD_CYC));

    // Count edges since reset release, saturating at the guard length.
    always_ff @(posedge clk) begin
        if (!rst_n)           guard_cnt <= '0;
        else if (!guard_done) guard_cnt <= guard_cnt + 1'b1;
    end

    // Advance between run, entry pulse, and the two sleep depths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_RUN;
        end else begin
            case (state)
                PS_RUN:   if (sleep_req && guard_done && !bus_busy) state <= PS_ENTRY;
                PS_ENTRY: state <= (cfg_awake && port_is_tp) ? PS_LIGHT : PS_DEEP;
                PS_DEEP,
                PS_LIGHT: if (!sleep_req) state <= PS_RUN;
                default:  state <= PS_RUN;
            endcase
        end
    end

    // Flag the cycle in which a sleeping block sees the request drop.
    assign wake_evt = ((state == PS_DEEP) || (state == PS_LIGHT)) && !sleep_req;

    p_entry_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_ENTRY) |=> (state == PS_DEEP || state == PS_LIGHT));
    p_busy_holdoff_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_RUN && bus_busy) |=> (state == PS_RUN));
    p_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_RUN && !guard_done) |=> (state == PS_RUN));
    p_deep_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_DEEP && sleep_req) |=> (state == PS_DEEP));
endmodule

// File: rtl/pwr_irq.sv
// Module: interrupt enables, sleep-interrupt status and the interrupt request.
// Assumes: writes are accepted only while wr_ok; soft_rst clears the master enable only.
module pwr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic wr_ok,
    input  logic ctl_wr,
    input  logic ctl_master_ie,
    input  logic ctl_slp_ie,
    input  logic ctl_slp_clr,
    input  logic wake_evt,
    input  logic core_irq_src,
    output logic irq
);
    logic master_ie;
    logic slp_ie;
    logic slp_int;
    logic wr_take;

    assign wr_take = wr_ok && ctl_wr;

    // Master enable: cleared by hard and soft reset, loaded by writes.
    always_ff @(posedge clk) begin
        if (!rst_n)        master_ie <= 1'b0;
        else if (soft_rst) master_ie <= 1'b0;
        else if (wr_take)  master_ie <= ctl_master_ie;
    end

    // Sleep-interrupt enable: survives the soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       slp_ie <= 1'b0;
        else if (wr_take) slp_ie <= ctl_slp_ie;
    end

    // Sleep-interrupt status: set on wake, cleared by a write of 1.
    always_ff @(posedge clk) begin
        if (!rst_n)                      slp_int <= 1'b0;
        else if (wake_evt)               slp_int <= 1'b1;
        else if (wr_take && ctl_slp_clr) slp_int <= 1'b0;
    end

    // Request combines both paths, gated off while the core is down.
    assign irq = wr_ok && ((master_ie && core_irq_src) || (slp_ie && slp_int));

    p_wake_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> slp_int);
    p_entry_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !master_ie);
    p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_take && ctl_slp_clr && !wake_evt) |=> !slp_int);
    p_slpie_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> $stable(slp_ie));
endmodule

// File: rtl/pwr_sleep_ctrl.sv
// Module: top of the sleep and wake power controller; decodes domain enables.
// Assumes: sleep_n is asynchronous; every other input is synchronous to clk.
module pwr_sleep_ctrl
    import pwr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int GUARD_CYC   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_n,
    input  logic cfg_awake,
    input  logic cfg_lnk_led_en,
    input  logic port_is_tp,
    input  logic bus_busy,
    input  logic link_good,
    input  logic core_irq_src,
    input  logic ctl_wr,
    input  logic ctl_master_ie,
    input  logic ctl_slp_ie,
    input  logic ctl_slp_clr,
    output logic core_en,
    output logic rxmon_en,
    output logic led_en,
    output logic tx_beat_en,
    output logic soft_rst,
    output logic link_led,
    output logic irq
);
    logic       sleep_sync_n;
    logic       wake_evt;
    logic       in_run;
    pwr_state_t state;

    pwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_n  (sleep_n),
        .dout_n (sleep_sync_n)
    );

    pwr_fsm #(.GUARD_CYC(GUARD_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (!sleep_sync_n),
        .cfg_awake  (cfg_awake),
        .port_is_tp (port_is_tp),
        .bus_busy   (bus_busy),
        .state      (state),
        .wake_evt   (wake_evt)
    );

    // Domain decode: core side stays up through the entry pulse.
    assign in_run     = (state == PS_RUN);
    assign core_en    = in_run || (state == PS_ENTRY);
    assign led_en     = core_en;
    assign tx_beat_en = core_en;
    assign rxmon_en   = (state != PS_DEEP);
    assign soft_rst   = (state == PS_ENTRY);
    assign link_led   = rxmon_en && cfg_lnk_led_en && link_good;

    pwr_irq u_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .soft_rst      (soft_rst),
        .wr_ok         (in_run),
        .ctl_wr        (ctl_wr),
        .ctl_master_ie (ctl_master_ie),
        .ctl_slp_ie    (ctl_slp_ie),
        .ctl_slp_clr   (ctl_slp_clr),
        .wake_evt      (wake_evt),
        .core_irq_src  (core_irq_src),
        .irq           (irq)
    );

    p_deep_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_DEEP) |-> (!irq && !link_led && !core_en));
    p_light_noirq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_LIGHT) |-> !irq);
endmodule

// File: tb/pwr_sleep_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_sleep_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n, sleep_n, cfg_awake, cfg_lnk_led_en, port_is_tp, bus_busy;
    logic link_good, core_irq_src, ctl_wr, ctl_master_ie, ctl_slp_ie, ctl_slp_clr;
    logic core_en, rxmon_en, led_en, tx_beat_en, soft_rst, link_led, irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pwr_sleep_ctrl u_pwr_sleep_ctrl (.*);

    // Vector bits: {lnk_en, link_good, irq_src, master_ie, exp_led, exp_irq}
    localparam logic [5:0] VEC [8] = '{
        6'b1100_10, 6'b1000_00, 6'b0100_00, 6'b0011_01,
        6'b1111_11, 6'b0010_00, 6'b0101_00, 6'b1110_10
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic wr(input logic mie, input logic sie, input logic clr);
        ctl_wr = 1'b1; ctl_master_ie = mie; ctl_slp_ie = sie; ctl_slp_clr = clr;
        tick(1);
        ctl_wr = 1'b0; ctl_slp_clr = 1'b0;
    endtask

    task automatic do_reset(input logic slp);
        rst_n = 1'b0; sleep_n = slp;
        tick(3);
        rst_n = 1'b1;
    endtask

    initial begin
        #800000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        cfg_awake = 0; cfg_lnk_led_en = 0; port_is_tp = 0; bus_busy = 0;
        link_good = 0; core_irq_src = 0; ctl_wr = 0; ctl_master_ie = 0;
        ctl_slp_ie = 0; ctl_slp_clr = 0;
        tick(1);
        do_reset(1'b1);
        tick(1);
        // R12 reset state
        chk(core_en, 1, "R12 core_en"); chk(rxmon_en, 1, "R12 rxmon_en");
        chk(led_en, 1, "R12 led_en");   chk(tx_beat_en, 1, "R12 tx_beat_en");
        chk(soft_rst, 0, "R12 soft_rst"); chk(irq, 0, "R12 irq");
        tick(4);

        // Table walk: R5 link LED and R11 interrupt combination in run mode
        foreach (VEC[i]) begin
            wr(VEC[i][2], 1'b0, 1'b0);
            cfg_lnk_led_en = VEC[i][5]; link_good = VEC[i][4]; core_irq_src = VEC[i][3];
            tick(1);
            chk(link_led, VEC[i][1], $sformatf("R5 vec%0d link_led", i));
            chk(irq, VEC[i][0], $sformatf("R11 vec%0d irq", i));
        end
        wr(0, 0, 0);
        core_irq_src = 0;

        // R8 guard: sleep held low through reset
        cfg_awake = 0;
        do_reset(1'b0);
        tick(3);
        chk(soft_rst, 0, "R8 no entry at third edge");
        tick(1);
        chk(soft_rst, 1, "R8 entry at fourth edge");
        tick(1);
        chk(soft_rst, 0, "R2 pulse one cycle");
        // R3 deep state, inputs ignored
        cfg_lnk_led_en = 1; link_good = 1; core_irq_src = 1;
        chk(core_en, 0, "R3 core_en"); chk(rxmon_en, 0, "R3 rxmon_en");
        chk(tx_beat_en, 0, "R3 tx_beat_en"); chk(link_led, 0, "R3 link_led");
        chk(irq, 0, "R3 irq");
        wr(1, 0, 0);
        cfg_awake = 1; port_is_tp = 1;
        tick(2);
        chk(rxmon_en, 0, "R3 awake change ignored");
        sleep_n = 1;
        tick(2);
        chk(core_en, 0, "R9 still asleep at edge j+1");
        tick(1);
        chk(core_en, 1, "R9 awake at edge j+2");
        chk(irq, 0, "R3 deep write ignored");
        wr(0, 1, 0);
        chk(irq, 1, "R9 sleep interrupt via its enable");
        wr(0, 1, 1);
        chk(irq, 0, "R10 status cleared by write 1");
        core_irq_src = 0;

        // R4 light state with R1 latency and R2 master clear
        wr(1, 0, 0);
        cfg_awake = 1; port_is_tp = 1; sleep_n = 0;
        tick(2);
        chk(soft_rst, 0, "R1 no entry at edge k+1");
        tick(1);
        chk(soft_rst, 1, "R1 entry at edge k+2");
        tick(1);
        chk(core_en, 0, "R4 core_en"); chk(rxmon_en, 1, "R4 rxmon_en");
        chk(led_en, 0, "R4 led_en");   chk(tx_beat_en, 0, "R4 tx_beat_en");
        link_good = 1; tick(1);
        chk(link_led, 1, "R5 light good link");
        link_good = 0; tick(1);
        chk(link_led, 0, "R5 light no link");
        sleep_n = 1;
        tick(3);
        core_irq_src = 1; tick(1);
        chk(irq, 0, "R2 master enable cleared by entry");
        wr(0, 1, 0);
        chk(irq, 1, "R9 wake interrupt bypasses master");
        wr(0, 0, 1);
        core_irq_src = 0;

        // R6 awake set but non twisted-pair port
        port_is_tp = 0; sleep_n = 0;
        tick(4);
        chk(rxmon_en, 0, "R6 deep when port not tp");
        sleep_n = 1; tick(3);
        chk(core_en, 1, "R6 woke");

        // R7 bus busy holds entry off
        bus_busy = 1; sleep_n = 0;
        tick(4);
        chk(soft_rst, 0, "R7 held while busy");
        chk(core_en, 1, "R7 still running");
        bus_busy = 0; tick(1);
        chk(soft_rst, 1, "R7 entry once idle");
        sleep_n = 1; tick(4);
        chk(core_en, 1, "R7 woke");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule